// File: doc/BRIEF.md
# Dual-Section Decade Ripple Counter

A four-bit counter built from two sections that are clocked by separate count inputs. The low section is one bit wide and divides by two; it steps on count input `cnt_a`. The high section is three bits wide and steps through five states; it steps on count input `cnt_b`. Wiring the two sections together outside the block gives either a BCD decade counter or a bi-quinary divider whose least significant bit is a symmetric square wave at one tenth of the input pulse rate.

Everything is clocked by one system clock. Each count input is sampled on every rising edge. A high-to-low change between two consecutive samples is a count event, so each section steps at most once per clock. Two AND-gated control pairs act as level overrides. One pair forces the output to zero. The other forces it to nine, and nine has priority over zero.

Top module: `decade_ripple_counter`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `q` reads 4'b0000.
- R2: `q[0]` inverts on the clock edge at which `cnt_a` is sampled low after having been sampled high on the edge before. A rising change or a steady `cnt_a` leaves `q[0]` as it is.
- R3: `q[3:1]` steps on falling `cnt_b` events through 3'b000, 001, 010, 011, 100 and then returns to 000. `cnt_b` never changes `q[0]`, and `cnt_a` never changes `q[3:1]`.
- R4: When `zero_req_1` and `zero_req_2` are both high and the set-to-nine pair is not both high, `q` is 4'b0000 after the next clock edge.
- R5: When `nine_req_1` and `nine_req_2` are both high, `q` is 4'b1001 (`q[3]`=1, `q[0]`=1) after the next clock edge, whatever the zero pair does.
- R6: A control pair with only one of its inputs high has no effect, and counting carries on normally.
- R7: A count event that falls in a clock cycle in which either override is active is discarded. It is not applied once the override is released.
- R8: When `cnt_b` is driven from a registered copy of `q[0]` and pulses are applied to `cnt_a`, `q` equals the number of pulses modulo 10 as a BCD digit.
- R9: When `cnt_a` is driven from a registered copy of `q[3]` and pulses are applied to `cnt_b`, after n pulses `q[3:1]` equals n mod 5 and `q[0]` equals (n/5) mod 2. `q[0]` is therefore a square wave with a period of ten pulses and a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the count inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_a | input | 1 | Count input of the divide-by-two section |
| cnt_b | input | 1 | Count input of the divide-by-five section |
| zero_req_1 | input | 1 | Force-to-zero control, first input of the AND pair |
| zero_req_2 | input | 1 | Force-to-zero control, second input of the AND pair |
| nine_req_1 | input | 1 | Force-to-nine control, first input of the AND pair |
| nine_req_2 | input | 1 | Force-to-nine control, second input of the AND pair |
| q | output | 4 | Counter value; bit 0 is the divide-by-two section, bits 3:1 are the divide-by-five section |

## Verification
The sections are first driven on their own. Pulses on one input must leave the other section frozen, which shows that the two count paths are separate and that only falling changes count. The four control inputs are then swept through all sixteen combinations from a non-zero state, which separates the single-input-high cases, force-to-zero and force-to-nine with its priority. Last come the two external chainings, BCD over thirty pulses and bi-quinary over thirty pulses. Each chaining must produce its own output code sequence, so a swapped section order or a wrong five-state wrap shows up in one of them.

// File: rtl/decade_ripple_pkg.sv
package decade_ripple_pkg;
  localparam int QUIN_W   = 3;
  localparam int QUIN_MOD = 5;
  localparam logic [QUIN_W-1:0] QUIN_NINE = QUIN_W'(QUIN_MOD - 1);

  // Next state of the modulo-QUIN_MOD section.
  function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] s);
    if (s == QUIN_W'(QUIN_MOD - 1)) return '0;
    return s + QUIN_W'(1);
  endfunction
endpackage

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign fall = prev_q & ~din;

  a_r2_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/half_stage.sv
module half_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic step,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= load_val;
    else if (step) q <= ~q;
  end

  a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (q != $past(q)));
endmodule

// File: rtl/quin_stage.sv
module quin_stage
  import decade_ripple_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [QUIN_W-1:0] load_val,
  input  logic              step,
  output logic [QUIN_W-1:0] q,
  output logic              wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= quin_next(q);
  end

  assign wrap = step && !load && (q == QUIN_NINE);

  a_r3_legal: assert property (@(posedge clk) disable iff (!rst_n)
    q < QUIN_W'(QUIN_MOD));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ((q == '0 && $past(q) == QUIN_W'(QUIN_MOD - 1)) ||
                         (int'(q) == int'($past(q)) + 1)));
endmodule

// File: rtl/decade_ripple_counter.sv
module decade_ripple_counter
  import decade_ripple_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_a,
  input  logic       cnt_b,
  input  logic       zero_req_1,
  input  logic       zero_req_2,
  input  logic       nine_req_1,
  input  logic       nine_req_2,
  output logic [3:0] q
);
  logic fall_a, fall_b;
  logic nine_hit, zero_hit, ovr;
  logic half_q, half_load_val;
  logic [QUIN_W-1:0] quin_q, quin_load_val;
  logic quin_wrap;

  assign nine_hit = nine_req_1 & nine_req_2;
  assign zero_hit = zero_req_1 & zero_req_2 & ~nine_hit;
  assign ovr      = nine_hit | zero_hit;

  assign half_load_val = nine_hit;
  assign quin_load_val = nine_hit ? QUIN_NINE : '0;

  fall_detect u_fall_a (.clk(clk), .rst_n(rst_n), .din(cnt_a), .fall(fall_a));
  fall_detect u_fall_b (.clk(clk), .rst_n(rst_n), .din(cnt_b), .fall(fall_b));

  half_stage u_half (
    .clk(clk), .rst_n(rst_n), .load(ovr), .load_val(half_load_val),
    .step(fall_a), .q(half_q)
  );

  quin_stage u_quin (
    .clk(clk), .rst_n(rst_n), .load(ovr), .load_val(quin_load_val),
    .step(fall_b), .q(quin_q), .wrap(quin_wrap)
  );

  assign q = {quin_q, half_q};

  a_r5_nine: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_req_1 && nine_req_2) |=> (q == 4'b1001));
  a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_req_1 && zero_req_2 && !(nine_req_1 && nine_req_2)) |=> (q == 4'b0000));
  a_r3_a_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_b && !ovr) |=> $stable(q[3:1]));
  a_r3_b_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_a && !ovr) |=> $stable(q[0]));
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    quin_wrap |=> (q[3:1] == 3'b000));
endmodule

// File: tb/test_decade_ripple_counter.sv
module test_decade_ripple_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_a = 1'b0, drv_b = 1'b0;
  logic chain_a = 1'b0, chain_b = 1'b0;
  logic z1 = 1'b0, z2 = 1'b0, n1 = 1'b0, n2 = 1'b0;
  int   mode = 0; // 0 direct, 1 BCD chain, 2 bi-quinary chain
  logic cnt_a, cnt_b;
  logic [3:0] q;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign cnt_a = (mode == 2) ? chain_a : drv_a;
  assign cnt_b = (mode == 1) ? chain_b : drv_b;

  // Registered copies of outputs used for external chaining.
  always @(negedge clk) begin
    chain_b <= q[0];
    chain_a <= q[3];
  end

  decade_ripple_counter i_decade_ripple_counter (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .zero_req_1(z1), .zero_req_2(z2), .nine_req_1(n1), .nine_req_2(n2), .q(q)
  );

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic pulse_a();
    drv_a = 1'b1; repeat (2) @(negedge clk);
    drv_a = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic pulse_b();
    drv_b = 1'b1; repeat (2) @(negedge clk);
    drv_b = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
  endtask

  function automatic logic [3:0] ctl_expect(input logic [3:0] c, input logic [3:0] prior);
    if (c[2] && c[3]) return 4'd9;
    if (c[0] && c[1]) return 4'd0;
    return prior;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] base;
    repeat (2) @(negedge clk);
    check("R1 in reset", q, 4'd0);
    rst_n = 1'b1; @(negedge clk);
    check("R1 after reset", q, 4'd0);

    // R2 latency: toggle appears exactly at the edge sampling the low level
    drv_a = 1'b1; @(negedge clk); @(negedge clk);
    check("R2 rising no count", q, 4'd0);
    drv_a = 1'b0;
    check("R2 before sampling edge", q, 4'd0);
    @(negedge clk);
    check("R2 toggle after fall", q, 4'd1);
    repeat (3) @(negedge clk);
    check("R2 steady no count", q, 4'd1);

    // R3: B-only sequence, q[0] left at 1
    for (int n = 1; n <= 7; n++) begin
      pulse_b();
      check("R3 quinary step", q, {3'(n % 5), 1'b1});
    end
    // R3: A pulses leave q[3:1]
    pulse_a();
    check("R3 A leaves upper", q, {3'(7 % 5), 1'b0});

    // R4/R5/R6: sweep all control combinations from a non-zero state
    for (int c = 0; c < 16; c++) begin
      do_reset();
      pulse_a(); pulse_b(); // q = 3
      base = q;
      {n2, n1, z2, z1} = 4'(c);
      repeat (2) @(negedge clk);
      check($sformatf("R4/R5/R6 ctl=%b", 4'(c)), q, ctl_expect(4'(c), 4'd3));
      {n2, n1, z2, z1} = 4'b0;
      @(negedge clk);
      if (base != 4'd3) check("R1 setup", base, 4'd3);
    end

    // R6: single inputs high while counting
    do_reset();
    z1 = 1'b1; n2 = 1'b1;
    pulse_a(); pulse_b();
    check("R6 counts with one input of each pair", q, 4'd3);
    z1 = 1'b0; n2 = 1'b0;

    // R7: events during override are lost
    n1 = 1'b1; n2 = 1'b1;
    pulse_a(); pulse_b();
    n1 = 1'b0; n2 = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 nine override swallows events", q, 4'd9);
    z1 = 1'b1; z2 = 1'b1;
    pulse_a();
    z1 = 1'b0; z2 = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 zero override swallows events", q, 4'd0);

    // R8: BCD chaining
    do_reset();
    mode = 1;
    for (int n = 1; n <= 30; n++) begin
      pulse_a();
      check($sformatf("R8 bcd n=%0d", n), q, 4'(n % 10));
    end
    mode = 0;
    drv_a = 1'b0; drv_b = 1'b0;

    // R9: bi-quinary chaining
    do_reset();
    repeat (2) @(negedge clk);
    mode = 2;
    for (int n = 1; n <= 30; n++) begin
      pulse_b();
      check($sformatf("R9 biquinary n=%0d", n), q, {3'(n % 5), 1'((n / 5) % 2)});
    end
    mode = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule